// File: doc/BRIEF.md
# Rotating-Parity Stripe Write Controller

The controller accepts single logical block writes for a five-column striped array that keeps one parity unit per stripe. Each stripe (one row across all columns) holds four data units and one parity unit, and the parity unit moves one column to the left on every successive stripe, wrapping after five stripes. For each logical address the block derives the stripe row, the column that holds the parity for that row, and the column that holds the addressed data unit.

A write is carried out as a read-modify-write of exactly four physical operations against per-column request/acknowledge storage ports. In order, it reads the old data, reads the old parity, writes the new data and writes the new parity. The new parity is the XOR of the old parity, the old data and the new data. While a sequence runs the block reports busy and takes no new write. It gives a single-cycle done pulse once the parity write has been acknowledged.

Top module: `rotpar_write_ctrl`

## Requirements
- R1: For logical address A, the stripe row is S = A / 4 and the parity column is 4 − (S mod 5). Every physical operation of the write uses row S, and the second and fourth operations target the parity column.
- R2: With idx = A mod 4, the data column is idx when idx is below the parity column, and idx + 1 otherwise. The first and third operations target this column.
- R3: Each accepted write issues exactly four operations in this order: read data column (col_we = 0), read parity column (col_we = 0), write data column with the new data (col_we = 1), write parity column (col_we = 1).
- R4: The value written in the fourth operation equals the old data XOR the old parity XOR the new data. The old data is col_rdata of the data column at its read acknowledge, and the old parity is col_rdata of the parity column at its read acknowledge. Starting from an all-zero array, the parity unit of each row therefore stays equal to the XOR of that row's four data units.
- R5: At most one col_req bit is high at a time. A request, together with its row, write enable and write data, stays unchanged until the acknowledge bit of that same column is seen. col_rdata of column c occupies bits [c*DATA_W +: DATA_W].
- R6: busy is high from the cycle after a write is accepted until the sequence completes. wr_valid is ignored while busy is high, and such a write causes no physical operation.
- R7: done is high for exactly one cycle. That cycle is the one after the fourth operation's acknowledge, and busy is low in it.
- R8: After reset, busy, done and all col_req bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Logical write request, taken when busy is low |
| wr_addr | input | LADDR_W | Logical block number |
| wr_data | input | DATA_W | New data for the block |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| col_req | output | 5 | Per-column operation request |
| col_we | output | 1 | 1 = write, 0 = read, for the active request |
| col_row | output | LADDR_W | Stripe row of the active request |
| col_wdata | output | DATA_W | Write data of the active request |
| col_ack | input | 5 | Per-column acknowledge |
| col_rdata | input | 5*DATA_W | Per-column read data, column c at [c*DATA_W +: DATA_W] |

## Verification
A wrong address decode shows up on the first request of a write, because the wrong col_req bit rises in the cycle after acceptance. A corrupted sequencer state shows up as a missing, repeated or reordered operation, which is visible within four acknowledges. A wrong parity register does not change the port order of operations. It does show in the fourth operation's write data and in the row parity no longer matching the XOR of its data, which is checked right after done. A busy flag that falls early lets an extra write through, and that write appears as a fifth operation in the same window.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
    localparam int NCOLS = 5;
    localparam int COL_W = $clog2(NCOLS);
    localparam int DPS   = NCOLS - 1;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_DATA,
        PH_RD_PAR,
        PH_WR_DATA,
        PH_WR_PAR
    } phase_e;

    function automatic logic phase_writes(phase_e p);
        return (p == PH_WR_DATA) || (p == PH_WR_PAR);
    endfunction

    function automatic logic phase_on_parity(phase_e p);
        return (p == PH_RD_PAR) || (p == PH_WR_PAR);
    endfunction

    function automatic phase_e phase_next(phase_e p);
        case (p)
            PH_RD_DATA: return PH_RD_PAR;
            PH_RD_PAR:  return PH_WR_DATA;
            PH_WR_DATA: return PH_WR_PAR;
            default:    return PH_IDLE;
        endcase
    endfunction
endpackage

// File: rtl/stripe_map.sv
module stripe_map
    import stripe_pkg::*;
#(
    parameter int LADDR_W = 8
) (
    input  logic [LADDR_W-1:0] laddr,
    output logic [LADDR_W-1:0] row,
    output col_t               pcol,
    output col_t               dcol
);
    logic [LADDR_W-1:0] idx_full;
    logic [LADDR_W-1:0] rot;
    col_t               idx;

    always_comb begin
        row      = laddr / LADDR_W'(DPS);
        idx_full = laddr % LADDR_W'(DPS);
        rot      = row % LADDR_W'(NCOLS);
        pcol     = COL_W'(NCOLS - 1) - COL_W'(rot);
        idx      = COL_W'(idx_full);
        dcol     = (idx >= pcol) ? idx + COL_W'(1) : idx;
    end

    // R2
    always_comb begin
        map_distinct_chk: assert (dcol != pcol && int'(dcol) < NCOLS && int'(pcol) < NCOLS)
            else $error("data and parity column collide");
    end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import stripe_pkg::*;
#(
    parameter int LADDR_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  col_t                    dcol_in,
    input  col_t                    pcol_in,
    input  logic [LADDR_W-1:0]      row_in,
    input  logic [DATA_W-1:0]       data_in,
    output logic                    busy,
    output logic                    done,
    output logic [NCOLS-1:0]        col_req,
    output logic                    col_we,
    output logic [LADDR_W-1:0]      col_row,
    output logic [DATA_W-1:0]       col_wdata,
    input  logic [NCOLS-1:0]        col_ack,
    input  logic [NCOLS*DATA_W-1:0] col_rdata
);
    phase_e              phase;
    col_t                dcol_r, pcol_r, cur_col;
    logic [LADDR_W-1:0]  row_r;
    logic [DATA_W-1:0]   new_r, oldd_r, par_r, rd_word;
    logic                done_r, ack_hit;

    always_comb begin
        cur_col   = phase_on_parity(phase) ? pcol_r : dcol_r;
        ack_hit   = (phase != PH_IDLE) && col_ack[cur_col];
        rd_word   = col_rdata[int'(cur_col)*DATA_W +: DATA_W];
        col_req   = (phase != PH_IDLE) ? (NCOLS'(1) << cur_col) : '0;
        col_we    = phase_writes(phase);
        col_row   = row_r;
        col_wdata = (phase == PH_WR_PAR) ? par_r : new_r;
        busy      = (phase != PH_IDLE);
        done      = done_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            done_r <= 1'b0;
            dcol_r <= '0;
            pcol_r <= '0;
            row_r  <= '0;
            new_r  <= '0;
            oldd_r <= '0;
            par_r  <= '0;
        end else begin
            done_r <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    dcol_r <= dcol_in;
                    pcol_r <= pcol_in;
                    row_r  <= row_in;
                    new_r  <= data_in;
                    phase  <= PH_RD_DATA;
                end
            end else if (ack_hit) begin
                phase <= phase_next(phase);
                if (phase == PH_RD_DATA) oldd_r <= rd_word;
                if (phase == PH_RD_PAR)  par_r  <= rd_word ^ oldd_r ^ new_r;
                if (phase == PH_WR_PAR)  done_r <= 1'b1;
            end
        end
    end

    // R5
    one_req_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(col_req));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (col_req != 0 && (col_req & col_ack) == 0) |=>
            ($stable(col_req) && $stable(col_we) && $stable(col_row) && $stable(col_wdata)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R3
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(col_we) |-> $past(col_req != 0 && !col_we));
endmodule

// File: rtl/rotpar_write_ctrl.sv
module rotpar_write_ctrl
    import stripe_pkg::*;
#(
    parameter int LADDR_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  logic [LADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    busy,
    output logic                    done,
    output logic [NCOLS-1:0]        col_req,
    output logic                    col_we,
    output logic [LADDR_W-1:0]      col_row,
    output logic [DATA_W-1:0]       col_wdata,
    input  logic [NCOLS-1:0]        col_ack,
    input  logic [NCOLS*DATA_W-1:0] col_rdata
);
    logic [LADDR_W-1:0] map_row;
    col_t               map_pcol, map_dcol;
    logic               start;

    assign start = wr_valid && !busy;

    stripe_map #(.LADDR_W(LADDR_W)) u_map (
        .laddr (wr_addr),
        .row   (map_row),
        .pcol  (map_pcol),
        .dcol  (map_dcol)
    );

    rmw_seq #(.LADDR_W(LADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dcol_in   (map_dcol),
        .pcol_in   (map_pcol),
        .row_in    (map_row),
        .data_in   (wr_data),
        .busy      (busy),
        .done      (done),
        .col_req   (col_req),
        .col_we    (col_we),
        .col_row   (col_row),
        .col_wdata (col_wdata),
        .col_ack   (col_ack),
        .col_rdata (col_rdata)
    );

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !busy) |=> busy);
endmodule

// File: tb/rotpar_write_ctrl_bench.sv
`timescale 1ns/1ps
module rotpar_write_ctrl_bench;
    localparam int LW = 8;
    localparam int DW = 32;
    localparam int NC = 5;
    localparam int NROWS = 1 << LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0;
    logic [LW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic busy, done, col_we;
    logic [NC-1:0] col_req;
    logic [NC-1:0] col_ack;
    logic [LW-1:0] col_row;
    logic [DW-1:0] col_wdata;
    logic [NC*DW-1:0] col_rdata;

    always #4 clk = ~clk;

    rotpar_write_ctrl #(.LADDR_W(LW), .DATA_W(DW)) u_rotpar_write_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .col_req(col_req),
        .col_we(col_we), .col_row(col_row), .col_wdata(col_wdata),
        .col_ack(col_ack), .col_rdata(col_rdata)
    );

    int tests = 0;
    int fails = 0;

    logic [DW-1:0] mem [NC][NROWS];
    int ops_n;
    int op_col [8];
    logic op_we [8];
    logic [LW-1:0] op_row [8];
    logic [DW-1:0] op_val [8];
    int cnt, dly;

    // storage model: acknowledges after a random wait, logs every operation
    always @(posedge clk) begin
        if (rst) begin
            col_ack <= '0;
            cnt <= 0;
            dly <= 0;
        end else begin
            col_ack <= '0;
            if (col_ack != 0) begin
                cnt <= 0;
            end else if (col_req != 0) begin
                if ($countones(col_req) > 1) begin
                    fails = fails + 1;
                    $display("FAIL R5 multiple requests: actual %b expected onehot", col_req);
                end
                if (cnt >= dly) begin
                    for (int c = 0; c < NC; c++) begin
                        if (col_req[c]) begin
                            col_ack[c] <= 1'b1;
                            col_rdata[c*DW +: DW] <= mem[c][col_row];
                            if (col_we) mem[c][col_row] <= col_wdata;
                            if (ops_n < 8) begin
                                op_col[ops_n] <= c;
                                op_we[ops_n]  <= col_we;
                                op_row[ops_n] <= col_row;
                                op_val[ops_n] <= col_we ? col_wdata : mem[c][col_row];
                            end
                            ops_n <= ops_n + 1;
                        end
                    end
                    cnt <= 0;
                    dly <= int'($urandom % 4);
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int e_row(input int a);
        return a / 4;
    endfunction
    function automatic int e_pcol(input int a);
        return 4 - ((a / 4) % 5);
    endfunction
    function automatic int e_dcol(input int a);
        int i;
        i = a % 4;
        return (i >= e_pcol(a)) ? i + 1 : i;
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit poke);
        int pc, dc, r, guard, pa, ppc, pdc;
        logic [DW-1:0] pold, rowx;
        pc = e_pcol(a); dc = e_dcol(a); r = e_row(a);
        pa = (a + 37) % NROWS;
        pdc = e_dcol(pa); ppc = e_pcol(pa);
        pold = mem[pdc][e_row(pa)];
        @(negedge clk);
        ops_n = 0;
        wr_valid = 1'b1; wr_addr = LW'(a); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        check(busy == 1'b1, "R6 busy after accept", busy, 1);
        if (poke) begin
            wr_valid = 1'b1; wr_addr = LW'(pa); wr_data = ~d;
        end
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        wr_valid = 1'b0;
        check(guard < 200, "R7 watchdog done", guard, 0);
        check(!busy, "R7 busy low with done", busy, 0);
        check(ops_n == 4, "R3 operation count", ops_n, 4);
        check(op_col[0] == dc && !op_we[0], "R2 op0 read data column", op_col[0], dc);
        check(op_col[1] == pc && !op_we[1], "R1 op1 read parity column", op_col[1], pc);
        check(op_col[2] == dc && op_we[2] && op_val[2] == d, "R3 op2 write new data", op_val[2], d);
        check(op_col[3] == pc && op_we[3], "R3 op3 parity write column", op_col[3], pc);
        check(op_row[0] == r && op_row[1] == r && op_row[2] == r && op_row[3] == r,
              "R1 row of operations", op_row[3], r);
        check(op_val[3] == (op_val[0] ^ op_val[1] ^ d), "R4 new parity value",
              op_val[3], op_val[0] ^ op_val[1] ^ d);
        rowx = '0;
        for (int c = 0; c < NC; c++) if (c != pc) rowx ^= mem[c][r];
        check(mem[pc][r] == rowx, "R4 row parity invariant", mem[pc][r], rowx);
        if (poke) begin
            check(mem[pdc][e_row(pa)] == pold || (pdc == dc && e_row(pa) == r),
                  "R6 write while busy ignored", mem[pdc][e_row(pa)], pold);
            check(ppc >= 0, "R6 poke target", ppc, ppc);
        end
        @(negedge clk);
        check(!done, "R7 done single cycle", done, 0);
        check(ops_n == 4, "R6 no extra operation", ops_n, 4);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NROWS; r++) mem[c][r] = '0;
        ops_n = 0;
        col_rdata = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && col_req == 0, "R8 reset state", {busy, done, col_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && col_req == 0, "R8 idle after reset", {busy, done, col_req}, 0);
        // directed corner cases: stripe 0, stripe 1 around parity, wrap at stripe 5, parity at column 0
        do_write(0,  32'h1111_0000, 1'b0);
        do_write(3,  32'h2222_0003, 1'b0);
        do_write(4,  32'h3333_0004, 1'b0);
        do_write(7,  32'h4444_0007, 1'b0);
        do_write(19, 32'h5555_0013, 1'b0);
        do_write(20, 32'h6666_0014, 1'b0);
        do_write(4,  32'hAAAA_5555, 1'b1);
        for (int i = 0; i < 60; i++)
            do_write(int'($urandom % NROWS), $urandom, (i % 5) == 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails = fails + 1;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule